// File: doc/BRIEF.md
# Group Register Rename Stage with Gated Table Reads

This block renames a group of `W` instructions every cycle. Each instruction carries two architectural source register numbers and one architectural destination. An internal alias table maps each architectural register to a physical register tag. The table has `2W` gated source read ports, `W` read ports for the previous mapping of each destination, and `W` write ports. New physical tags for the destinations come from a free-list input that is supplied `W` at a time.

Within a group, comparators check each instruction's destination against the sources of every younger instruction. A source that has an older in-group writer takes that writer's new tag. The table read port for that source gets its enable driven low, so the sensed value is never produced. The previous mapping reported for each destination follows the same nearest-older-writer rule. At the clock edge that accepts the group, the table takes all `W` new mappings. Where several lanes share a destination, the youngest lane's tag is the one that stays.

Renaming is combinational within the cycle. A group is accepted only when the free list offers a full set of `W` tags. The handshake is ready/valid, and the acceptance pops those tags.

Top module: `rename_stage`

## Requirements
- R1: After reset, the table maps architectural register r to physical tag r for every r.
- R2: Lane i occupies bits [i*AW +: AW] of the source and destination buses and bits [i*PW +: PW] of the tag buses. Lane 0 is the oldest instruction. A source with no older in-group writer gets the table mapping, which reflects every group accepted before the current cycle.
- R3: A source that an older lane of the same group writes gets the new tag of the nearest such older lane.
- R4: A source read enable is 1 exactly when `in_valid` is 1 and no older lane in the group writes that source register. Otherwise it is 0, so lane 0's enables equal `in_valid`.
- R5: The new destination tag of lane i equals free tag lane i.
- R6: The old mapping of lane i's destination is the new tag of the nearest older lane with the same destination if one exists, and otherwise the table mapping.
- R7: When several lanes of an accepted group write the same architectural register, the table keeps the tag of the youngest such lane.
- R8: `in_ready` equals `free_valid`. The group is accepted, and `free_take` is 1, exactly when `in_valid` and `free_valid` are both 1. Without acceptance, the table does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Group present on the inputs |
| in_ready | output | 1 | Stage can accept the group |
| src_a | input | W*AW | First source of each lane |
| src_b | input | W*AW | Second source of each lane |
| dst | input | W*AW | Destination of each lane |
| free_valid | input | 1 | W free tags are available |
| free_tags | input | W*PW | Free physical tags, one per lane |
| free_take | output | 1 | Free tags consumed this cycle |
| ren_a | output | W*PW | Renamed first sources |
| ren_b | output | W*PW | Renamed second sources |
| new_dst | output | W*PW | Newly assigned destination tags |
| old_dst | output | W*PW | Previous destination mappings |
| rd_en_a | output | W | Table read enable, first sources |
| rd_en_b | output | W | Table read enable, second sources |

## Verification
The checker assumes that the free-list tags are stable and meaningful in any cycle where `free_valid` is high. It also assumes that the source and destination buses hold a real group whenever `in_valid` is high, since the bypass properties compare them with no further qualification. The carry-over property assumes that lane 0 of the group following an acceptance reads the table, which holds because lane 0 never has an in-group producer. The stimulus always holds a legal group and tag set. It toggles both valids at random, draws registers from a narrow range to force repeated destinations and chains of dependencies, and draws from the full range in a later phase.

// File: rtl/rename_pkg.sv
package rename_pkg;
   localparam int unsigned DEF_LANES     = 4;
   localparam int unsigned DEF_ARCH_REGS = 32;
   localparam int unsigned DEF_PHYS_REGS = 64;

   function automatic int unsigned sel_width(input int unsigned lanes);
      return (lanes > 1) ? $clog2(lanes) : 1;
   endfunction
endpackage

// File: rtl/rename_rat.sv
module rename_rat #(
   parameter int unsigned W         = 4,
   parameter int unsigned ARCH_REGS = 32,
   parameter int unsigned AW        = 5,
   parameter int unsigned PW        = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2*W*AW-1:0] rd_idx,
   input  logic [2*W-1:0]    rd_en,
   output logic [2*W*PW-1:0] rd_tag,
   input  logic [W*AW-1:0]   od_idx,
   input  logic              od_en,
   output logic [W*PW-1:0]   od_tag,
   input  logic              wr_en,
   input  logic [W*AW-1:0]   wr_idx,
   input  logic [W*PW-1:0]   wr_tag
);
   logic [PW-1:0] map_q [ARCH_REGS];

   for (genvar p = 0; p < 2*W; p++) begin : g_src_port
      assign rd_tag[p*PW +: PW] = rd_en[p] ? map_q[rd_idx[p*AW +: AW]] : '0;
   end

   for (genvar p = 0; p < W; p++) begin : g_old_port
      assign od_tag[p*PW +: PW] = od_en ? map_q[od_idx[p*AW +: AW]] : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < ARCH_REGS; e++) map_q[e] <= PW'(e);
      end else if (wr_en) begin
         for (int i = 0; i < W; i++) map_q[wr_idx[i*AW +: AW]] <= wr_tag[i*PW +: PW];
      end
   end
endmodule

// File: rtl/rename_producer.sv
module rename_producer #(
   parameter int unsigned W    = 4,
   parameter int unsigned AW   = 5,
   parameter int unsigned LANE = 0,
   parameter int unsigned SW   = 2
) (
   input  logic [W*AW-1:0] dsts,
   input  logic [AW-1:0]   key,
   output logic            hit,
   output logic [SW-1:0]   sel
);
   always_comb begin
      hit = 1'b0;
      sel = '0;
      for (int j = 0; j < int'(LANE); j++) begin
         if (dsts[j*AW +: AW] == key) begin
            hit = 1'b1;
            sel = SW'(j);
         end
      end
   end
endmodule

// File: rtl/rename_stage.sv
module rename_stage
   import rename_pkg::*;
#(
   parameter int unsigned W         = DEF_LANES,
   parameter int unsigned ARCH_REGS = DEF_ARCH_REGS,
   parameter int unsigned PHYS_REGS = DEF_PHYS_REGS,
   parameter int unsigned AW        = $clog2(ARCH_REGS),
   parameter int unsigned PW        = $clog2(PHYS_REGS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   output logic            in_ready,
   input  logic [W*AW-1:0] src_a,
   input  logic [W*AW-1:0] src_b,
   input  logic [W*AW-1:0] dst,
   input  logic            free_valid,
   input  logic [W*PW-1:0] free_tags,
   output logic            free_take,
   output logic [W*PW-1:0] ren_a,
   output logic [W*PW-1:0] ren_b,
   output logic [W*PW-1:0] new_dst,
   output logic [W*PW-1:0] old_dst,
   output logic [W-1:0]    rd_en_a,
   output logic [W-1:0]    rd_en_b
);
   localparam int unsigned SW = sel_width(W);

   if (W < 1) begin : g_bad_lanes
      $error("rename_stage: W must be at least 1");
   end
   if (PHYS_REGS <= ARCH_REGS) begin : g_bad_phys
      $error("rename_stage: PHYS_REGS must exceed ARCH_REGS");
   end
   if ((1 << AW) != ARCH_REGS) begin : g_bad_arch
      $error("rename_stage: ARCH_REGS must be a power of two");
   end

   logic              fire;
   logic [2*W*AW-1:0] rd_idx;
   logic [2*W-1:0]    rd_en;
   logic [2*W*PW-1:0] rd_tag;
   logic [W*PW-1:0]   od_tag;
   logic [W-1:0]      hit_a, hit_b, hit_d;
   logic [SW-1:0]     sel_a [W];
   logic [SW-1:0]     sel_b [W];
   logic [SW-1:0]     sel_d [W];

   assign in_ready  = free_valid;
   assign fire      = in_valid && free_valid;
   assign free_take = fire;
   assign new_dst   = free_tags;

   assign rd_idx = {src_b, src_a};
   assign rd_en  = {rd_en_b, rd_en_a};

   for (genvar i = 0; i < W; i++) begin : g_lane
      rename_producer #(.W(W), .AW(AW), .LANE(i), .SW(SW)) u_pa (
         .dsts(dst), .key(src_a[i*AW +: AW]), .hit(hit_a[i]), .sel(sel_a[i]));
      rename_producer #(.W(W), .AW(AW), .LANE(i), .SW(SW)) u_pb (
         .dsts(dst), .key(src_b[i*AW +: AW]), .hit(hit_b[i]), .sel(sel_b[i]));
      rename_producer #(.W(W), .AW(AW), .LANE(i), .SW(SW)) u_pd (
         .dsts(dst), .key(dst[i*AW +: AW]), .hit(hit_d[i]), .sel(sel_d[i]));

      assign rd_en_a[i] = in_valid && !hit_a[i];
      assign rd_en_b[i] = in_valid && !hit_b[i];

      assign ren_a[i*PW +: PW] = hit_a[i] ? free_tags[sel_a[i]*PW +: PW]
                                          : rd_tag[i*PW +: PW];
      assign ren_b[i*PW +: PW] = hit_b[i] ? free_tags[sel_b[i]*PW +: PW]
                                          : rd_tag[(W+i)*PW +: PW];
      assign old_dst[i*PW +: PW] = hit_d[i] ? free_tags[sel_d[i]*PW +: PW]
                                            : od_tag[i*PW +: PW];
   end

   rename_rat #(.W(W), .ARCH_REGS(ARCH_REGS), .AW(AW), .PW(PW)) u_rat (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (rd_idx),
      .rd_en  (rd_en),
      .rd_tag (rd_tag),
      .od_idx (dst),
      .od_en  (in_valid),
      .od_tag (od_tag),
      .wr_en  (fire),
      .wr_idx (dst),
      .wr_tag (free_tags)
   );
endmodule

// File: rtl/rename_checker.sv
module rename_checker #(
   parameter int unsigned W  = 4,
   parameter int unsigned AW = 5,
   parameter int unsigned PW = 6
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic [W*AW-1:0] src_a,
   input logic [W*AW-1:0] dst,
   input logic            free_valid,
   input logic [W*PW-1:0] free_tags,
   input logic            free_take,
   input logic [W*PW-1:0] ren_a,
   input logic [W*PW-1:0] old_dst,
   input logic [W-1:0]    rd_en_a,
   input logic [W-1:0]    rd_en_b
);
   assert_idle_reads_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> (rd_en_a == '0 && rd_en_b == '0));

   assert_lane0_reads_R4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (rd_en_a[0] && rd_en_b[0]));

   assert_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
      free_take |-> (in_valid && free_valid));

   // R7: the youngest lane's tag is visible to the next group through the table
   assert_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      free_take ##1 (in_valid && src_a[0 +: AW] == $past(dst[(W-1)*AW +: AW]))
      |-> ren_a[0 +: PW] == $past(free_tags[(W-1)*PW +: PW]));

   if (W >= 2) begin : g_pair
      assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && src_a[AW +: AW] == dst[0 +: AW])
         |-> (ren_a[PW +: PW] == free_tags[0 +: PW] && !rd_en_a[1]));

      assert_old_map_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && dst[AW +: AW] == dst[0 +: AW])
         |-> old_dst[PW +: PW] == free_tags[0 +: PW]);
   end
endmodule

bind rename_stage rename_checker #(.W(W), .AW(AW), .PW(PW)) u_rename_chk (.*);

// File: tb/tb_rename_stage.sv
`timescale 1ns/1ps
module tb_rename_stage;
   localparam int W = 4, ARCH = 32, PHYS = 64, AW = 5, PW = 6;
   localparam int CYCLES = 3000;

   logic            clk = 0, rst_n = 0;
   logic            in_valid = 0, in_ready, free_valid = 0, free_take;
   logic [W*AW-1:0] src_a = '0, src_b = '0, dst = '0;
   logic [W*PW-1:0] free_tags = '0, ren_a, ren_b, new_dst, old_dst;
   logic [W-1:0]    rd_en_a, rd_en_b;

   int total = 0, bad = 0, next_tag = 0;
   bit done = 0;
   int map [ARCH];

   always #5 clk = ~clk;

   rename_stage #(.W(W), .ARCH_REGS(ARCH), .PHYS_REGS(PHYS)) dut (.*);

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // one cycle: drive at negedge, compare mid-cycle, commit the model at posedge
   task automatic step(input bit v, input bit fv, input int rng);
      int tmp [ARCH];
      @(negedge clk);
      in_valid = v; free_valid = fv;
      for (int i = 0; i < W; i++) begin
         src_a[i*AW +: AW] = AW'($urandom_range(rng-1));
         src_b[i*AW +: AW] = AW'($urandom_range(rng-1));
         dst[i*AW +: AW]   = AW'($urandom_range(rng-1));
         free_tags[i*PW +: PW] = PW'(next_tag);
         next_tag = (next_tag + 1) % PHYS;
      end
      #2;
      tmp = map;
      for (int i = 0; i < W; i++) begin
         int sa = int'(src_a[i*AW +: AW]);
         int sb = int'(src_b[i*AW +: AW]);
         int d  = int'(dst[i*AW +: AW]);
         bit ha = 0, hb = 0;
         for (int j = 0; j < i; j++) begin
            if (int'(dst[j*AW +: AW]) == sa) ha = 1;
            if (int'(dst[j*AW +: AW]) == sb) hb = 1;
         end
         check(rd_en_a[i] == (v && !ha), "R4 rd_en_a", rd_en_a[i], v && !ha);
         check(rd_en_b[i] == (v && !hb), "R4 rd_en_b", rd_en_b[i], v && !hb);
         check(new_dst[i*PW +: PW] == free_tags[i*PW +: PW], "R5 new_dst",
               new_dst[i*PW +: PW], free_tags[i*PW +: PW]);
         if (v) begin
            check(int'(ren_a[i*PW +: PW]) == tmp[sa], ha ? "R3 ren_a" : "R2/R7 ren_a",
                  ren_a[i*PW +: PW], tmp[sa]);
            check(int'(ren_b[i*PW +: PW]) == tmp[sb], hb ? "R3 ren_b" : "R2/R7 ren_b",
                  ren_b[i*PW +: PW], tmp[sb]);
            check(int'(old_dst[i*PW +: PW]) == tmp[d], "R6 old_dst",
                  old_dst[i*PW +: PW], tmp[d]);
         end
         tmp[d] = int'(free_tags[i*PW +: PW]);
      end
      check(in_ready == fv, "R8 in_ready", in_ready, fv);
      check(free_take == (v && fv), "R8 free_take", free_take, v && fv);
      @(posedge clk);
      if (v && fv) map = tmp;
   endtask

   initial begin
      repeat (CYCLES * 4) @(posedge clk);
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", total, 0);
      finish_run();
   end

   initial begin
      for (int r = 0; r < ARCH; r++) map[r] = r;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      // R1: identity mapping right after reset, no in-group writers, no acceptance
      @(negedge clk);
      in_valid = 1; free_valid = 0;
      for (int i = 0; i < W; i++) begin
         src_a[i*AW +: AW] = AW'(i);
         src_b[i*AW +: AW] = AW'(i + 8);
         dst[i*AW +: AW]   = AW'(i + 20);
      end
      #2;
      for (int i = 0; i < W; i++) begin
         check(int'(ren_a[i*PW +: PW]) == i, "R1 ren_a", ren_a[i*PW +: PW], i);
         check(int'(ren_b[i*PW +: PW]) == i + 8, "R1 ren_b", ren_b[i*PW +: PW], i + 8);
         check(int'(old_dst[i*PW +: PW]) == i + 20, "R1 old_dst", old_dst[i*PW +: PW], i + 20);
      end
      check(free_take == 0, "R8 stall", free_take, 0);
      // stalled groups must leave the table untouched (R8), checked by later reads
      for (int c = 0; c < 20; c++) step(1, 0, 4);
      // narrow register range: repeated destinations and chains (R3, R6, R7)
      for (int c = 0; c < 1200; c++) step($urandom_range(99) < 85, $urandom_range(99) < 75, 4);
      // full register range
      for (int c = 0; c < 1200; c++) step($urandom_range(99) < 85, $urandom_range(99) < 80, ARCH);
      @(negedge clk); in_valid = 0; free_valid = 0;
      finish_run();
   end
endmodule